// File: doc/BRIEF.md
# Link Start-up Latency Meter

This block measures how many link clock cycles pass between the moment a receiver releases its synchronization request (the active-low sync line rises) and the moment the receiver first flags valid user data. Repeated link start-ups cause this figure to drift. The block therefore keeps the result of the last start-up and a running minimum and maximum over all start-ups since reset. A single flag shows whether the spread stays within one link clock.

The meter arms only on a low-to-high transition of the sync line. It counts until link-valid is seen high and then freezes the result. The result is held until the sync line drops again, which re-arms the meter, or until reset. If the sync line drops before link-valid arrives, the run is discarded. The counter saturates instead of wrapping.

Top module: `link_latency_meter`

## Requirements
- R1: While reset is asserted, and after it is released, `lat_count` is 0 and `lat_done`, `rec_valid` and `spread_ok` are 0.
- R2: A run starts only at a clock edge that samples `sync_n` high after an edge that sampled it low. If `sync_n` is already high when reset is released, nothing is armed: `link_valid` then leaves `lat_done` at 0 and `lat_count` at 0.
- R3: Let E0 be the starting edge and Ek the first later edge that samples `link_valid` high with `sync_n` still high. From Ek on, `lat_done` is 1 and `lat_count` equals k.
- R4: While `sync_n` stays high, a finished result holds: `lat_count` and `lat_done` do not change, whatever `link_valid` does.
- R5: An edge that samples `sync_n` low clears `lat_done` and `lat_count`. If the run was not finished, it is dropped and the records are left untouched.
- R6: The count saturates at 2^CW-1 (1023 for the default CW=10) and never wraps.
- R7: At each finished run, `rec_min` and `rec_max` take the smallest and largest result since reset, and `rec_valid` becomes 1. After the first run both equal that result.
- R8: `spread_ok` is 1 exactly when `rec_valid` is 1 and `rec_max - rec_min` is at most 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n | input | 1 | Receiver synchronization request, active low |
| link_valid | input | 1 | Receiver first-user-data indication |
| lat_count | output | CW | Running, then latched, latency in link clocks |
| lat_done | output | 1 | Latched result is final |
| rec_min | output | CW | Smallest result since reset |
| rec_max | output | CW | Largest result since reset |
| rec_valid | output | 1 | At least one run has finished |
| spread_ok | output | 1 | Recorded spread is at most one clock |

## Verification
The hardest state to reach is a history whose spread first widens past one clock after several runs that were within tolerance. Reaching it needs a sequence of complete start-ups, each with its own sync release and re-arm. The stimulus is a table of latencies (67, 68, 67, 66, 70). Each row is replayed as a full sync-release, link-valid, sync-reassert cycle. Directed runs then cover an aborted start-up, a sync line that is already high out of reset, and a run long enough to saturate the counter.

// File: rtl/link_latency_meter.sv
module link_latency_meter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_n,
  input  logic          link_valid,
  output logic [CW-1:0] lat_count,
  output logic          lat_done,
  output logic [CW-1:0] rec_min,
  output logic [CW-1:0] rec_max,
  output logic          rec_valid,
  output logic          spread_ok
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;
  st_t st;
  logic sync_q;
  logic [CW-1:0] cnt, nxt;

  wire arm  = sync_n & ~sync_q;
  wire stop = (st == S_RUN) & sync_n & link_valid;

  assign nxt = (cnt == CMAX) ? cnt : cnt + ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sync_q <= 1'b1;
      cnt    <= '0;
    end else begin
      sync_q <= sync_n;
      if (!sync_n) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          S_IDLE: if (arm) begin
            st  <= S_RUN;
            cnt <= '0;
          end
          S_RUN: begin
            cnt <= nxt;
            if (link_valid) st <= S_DONE;
          end
          S_DONE: ;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_min   <= '0;
      rec_max   <= '0;
      rec_valid <= 1'b0;
    end else if (stop) begin
      if (!rec_valid || nxt < rec_min) rec_min <= nxt;
      if (!rec_valid || nxt > rec_max) rec_max <= nxt;
      rec_valid <= 1'b1;
    end
  end

  assign lat_count = cnt;
  assign lat_done  = (st == S_DONE);
  assign spread_ok = rec_valid && ((rec_max - rec_min) <= ONE);
endmodule

// File: rtl/link_latency_meter_chk.sv
module link_latency_meter_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_n,
  input logic          link_valid,
  input logic [CW-1:0] lat_count,
  input logic          lat_done,
  input logic [CW-1:0] rec_min,
  input logic [CW-1:0] rec_max,
  input logic          rec_valid,
  input logic          spread_ok
);
  // R5
  rearm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> (!lat_done && lat_count == '0));
  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_done && sync_n) |=> (lat_done && $stable(lat_count)));
  // R7
  min_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_min <= rec_max));
  // R7
  record_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> rec_valid);
  // R7
  result_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_done) |-> (rec_valid && lat_count >= rec_min && lat_count <= rec_max));
  // R8
  ok_needs_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spread_ok |-> rec_valid);
endmodule

bind link_latency_meter link_latency_meter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .link_valid(link_valid),
  .lat_count(lat_count), .lat_done(lat_done), .rec_min(rec_min),
  .rec_max(rec_max), .rec_valid(rec_valid), .spread_ok(spread_ok)
);

// File: tb/tb_link_latency_meter.sv
module tb_link_latency_meter;
  localparam int CW = 10;
  logic clk = 1'b0, rst_n = 1'b0, sync_n = 1'b0, link_valid = 1'b0;
  logic [CW-1:0] lat_count, rec_min, rec_max;
  logic lat_done, rec_valid, spread_ok;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  link_latency_meter #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .link_valid(link_valid),
    .lat_count(lat_count), .lat_done(lat_done), .rec_min(rec_min),
    .rec_max(rec_max), .rec_valid(rec_valid), .spread_ok(spread_ok)
  );

  // rows: latency, expected min, expected max, expected spread_ok
  localparam int NV = 5;
  localparam int VEC [NV][4] = '{
    '{67, 67, 67, 1}, '{68, 67, 68, 1}, '{67, 67, 68, 1},
    '{66, 66, 68, 0}, '{70, 66, 70, 0}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int len);
    @(negedge clk) sync_n = 1'b1;
    repeat (len) @(negedge clk);
    link_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic rearm();
    link_valid = 1'b0;
    sync_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit sync_level);
    sync_n = sync_level;
    link_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 during reset
    chk(lat_count == 0 && !lat_done && !rec_valid && !spread_ok, "R1", lat_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lat_count == 0 && !lat_done, "R1", lat_done, 0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][0]);
      chk(lat_done && lat_count == CW'(VEC[i][0]), "R3", lat_count, VEC[i][0]);
      chk(rec_valid && rec_min == CW'(VEC[i][1]), "R7", rec_min, VEC[i][1]);
      chk(rec_max == CW'(VEC[i][2]), "R7", rec_max, VEC[i][2]);
      chk(spread_ok == VEC[i][3][0], "R8", spread_ok, VEC[i][3]);
      rearm();
      chk(!lat_done && lat_count == 0, "R5", lat_count, 0);
    end

    // R4: hold while sync_n high, link_valid toggling
    run(5);
    link_valid = 1'b0;
    repeat (3) @(negedge clk);
    link_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(lat_done && lat_count == 5, "R4", lat_count, 5);
    chk(rec_min == 5 && rec_max == 70, "R7", rec_min, 5);
    rearm();

    // R1 after reset history cleared
    do_reset(1'b0);
    chk(!rec_valid && !spread_ok && rec_min == 0 && rec_max == 0, "R1", rec_valid, 0);

    // R5: abort unfinished run
    @(negedge clk) sync_n = 1'b1;
    repeat (10) @(negedge clk);
    sync_n = 1'b0;
    @(negedge clk);
    chk(!lat_done && lat_count == 0, "R5", lat_count, 0);
    chk(!rec_valid, "R5", rec_valid, 0);
    run(3);
    chk(lat_done && lat_count == 3, "R3", lat_count, 3);
    chk(rec_min == 3 && rec_max == 3 && spread_ok, "R8", rec_max, 3);
    rearm();

    // R2: sync_n high through reset does not arm
    do_reset(1'b1);
    link_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(!lat_done && lat_count == 0, "R2", lat_count, 0);
    chk(!rec_valid, "R2", rec_valid, 0);
    rearm();

    // R6: saturation
    run(1100);
    chk(lat_done && lat_count == 1023, "R6", lat_count, 1023);
    chk(rec_min == 1023 && rec_max == 1023, "R6", rec_max, 1023);
    rearm();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule